// File: doc/BRIEF.md
# Directory DMA Coherence Engine

This block sits at the home directory of a broadcast-snooping coherence system and serves DMA reads and writes to whole cache lines. For each line it keeps one of three stable directory states: exclusive-at-memory (E), memory-owner with possible cached copies (O), and not-owner, where some cache holds the only valid dirty copy (NO). It accepts one DMA request at a time and sends a probe to every last-level cache: shared for reads, exclusive for writes. It then counts exactly one response per cache and, for reads from E or O, fetches the line from memory.

Data that a cache returns always takes priority over data from memory. A read finishes by returning the full line to the DMA requester and settling in O or E, depending on whether any cache reported that it kept a shared copy. A write finishes by laying the DMA bytes over the current line, writing the result to memory and, after memory acknowledges, returning an acknowledgement. While a transaction is open, its line is frozen: new DMA requests are not consumed, and the CPU-side request path is told to stall on that line. That path reports stable-state changes through a grant input.

Top module: `dma_dir_engine`

## Requirements
- R1: After reset every line is in state E, `dmaReqReady` is 1 and `dmaRspValid`, `probeValid`, `memReqValid`, `protoErr` and `cpuStall` are 0.
- R2: A request is consumed only on a cycle where `dmaReqValid` and `dmaReqReady` are both 1. `dmaReqReady` is 0 from the cycle after acceptance until the transaction completes, and a request held during that time is not consumed. `cpuStall` is 1 when `cpuReqLine` equals the open transaction's line, or when the block is idle and `cpuReqLine` equals a line being requested on `dmaReqValid`. Otherwise `cpuStall` is 0.
- R3: In the cycle after acceptance, `probeValid` pulses for one cycle with `probeLine` set to the request line and `probeExcl` equal to the request's write flag (1 = write, 0 = read).
- R4: In the cycle after acceptance, a read of a line in E or O issues a memory read (`memReqValid`=1, `memReqWrite`=0, `memReqLine`=line). A read of a line in NO, or any write, issues no memory read.
- R5: The pending counter starts at NUM_CACHES. Each cycle with `cacheRspValid` counts as exactly one response, whatever its kind. No completion happens until all NUM_CACHES responses have arrived.
- R6: `cacheRspKind` is encoded 0 = ack, 1 = shared ack, 2 = shared data, 3 = exclusive data. A data kind (2 or 3) replaces the buffered line and marks it dirty. Memory data is buffered only if no cache data has arrived before it or in the same cycle.
- R7: A read from E or NO completes on the second clock edge after its last required input (the last cache response, and the memory data when a fetch was issued). It returns one `dmaRspValid` pulse with `dmaRspIsData`=1 and the full buffered line. The line then goes to O if a shared kind (1 or 2) was seen, otherwise to E.
- R8: A read from O forwards the memory data on `dmaRsp` in the cycle after `memRdValid`. It sends no second response at completion, and the line stays in O.
- R9: A write completes on the second clock edge after its last cache response by issuing one memory write. The DMA bytes are those with index i where `dmaReqOffset` <= i < `dmaReqOffset`+`dmaReqLen`, clipped at the end of the line. They are laid over the buffered line. `memWrMask` is all ones if a cache returned data, otherwise only the DMA bytes.
- R10: In the cycle after `memWrAck`, a write sends `dmaRspValid`=1 with `dmaRspIsData`=0, and the line goes to E.
- R11: `protoErr` pulses together with the read response when a read that started in NO saw neither a shared kind nor any cache data.
- R12: `cpuGrantValid` writes `cpuGrantState` (0 = E, 1 = O, 2 = NO, 3 = no change) into line `cpuReqLine` at the next edge. This happens only when `cpuStall` is 0; a grant made while stalled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReqValid | input | 1 | DMA request present |
| dmaReqReady | output | 1 | Engine idle; request consumed when both are high |
| dmaReqWrite | input | 1 | 1 = write, 0 = read |
| dmaReqLine | input | IDX_W | Line index |
| dmaReqOffset | input | OFS_W | Byte offset of the physical address inside the line |
| dmaReqLen | input | OFS_W+1 | Byte count for a write |
| dmaReqData | input | 8*LINE_BYTES | Write data, byte-aligned to the line |
| dmaRspValid | output | 1 | Response pulse to the DMA requester |
| dmaRspIsData | output | 1 | 1 = line data, 0 = write acknowledgement |
| dmaRspData | output | 8*LINE_BYTES | Full line for a read |
| probeValid | output | 1 | Broadcast probe pulse to all caches |
| probeExcl | output | 1 | 1 = exclusive probe, 0 = shared probe |
| probeLine | output | IDX_W | Probed line |
| cacheRspValid | input | 1 | One cache response |
| cacheRspKind | input | 2 | Response kind (see R6) |
| cacheRspData | input | 8*LINE_BYTES | Line data for data kinds |
| memReqValid | output | 1 | Memory request pulse |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqLine | output | IDX_W | Memory line |
| memWrData | output | 8*LINE_BYTES | Line to write |
| memWrMask | output | LINE_BYTES | Byte enables for the write |
| memRdValid | input | 1 | Memory read data present |
| memRdData | input | 8*LINE_BYTES | Memory read data |
| memWrAck | input | 1 | Memory write done |
| cpuReqLine | input | IDX_W | Line of the CPU-side request or grant |
| cpuStall | output | 1 | CPU-side request must retry |
| cpuGrantValid | input | 1 | CPU path writes a stable state |
| cpuGrantState | input | 2 | New stable state (see R12) |
| protoErr | output | 1 | Protocol error pulse |

## Verification
The probe and the memory read appear one cycle after acceptance. Forwarded owner data appears one cycle after `memRdValid`, and the write acknowledgement one cycle after `memWrAck`. A read's data response and a write's memory request both appear two edges after the last required input, because the completion decision is taken from registered counts. Every scenario task drives its inputs just after a falling edge and samples outputs at a later falling edge counted from those latencies. It also samples the intermediate cycles, to show that nothing arrives early or twice. Final stable states are observed through the next transaction on the same line: whether a memory read is issued and whether the data arrives early.

// File: rtl/dma_dir_pkg.sv
package dma_dir_pkg;

  typedef enum logic [1:0] {
    DIR_E  = 2'd0,
    DIR_O  = 2'd1,
    DIR_NO = 2'd2
  } dirState_e;

  typedef enum logic [1:0] {
    RSP_ACK    = 2'd0,
    RSP_SHACK  = 2'd1,
    RSP_SHDATA = 2'd2,
    RSP_EXDATA = 2'd3
  } cacheRsp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic issueMemRd;
    logic takeCache;
    logic takeMem;
    logic fwdMem;
    logic sendBuf;
    logic issueMemWr;
    logic fullLine;
    logic sendAck;
    logic flagErr;
  } dpCtl_t;

endpackage

// File: rtl/dma_dir_table.sv
module dma_dir_table
  import dma_dir_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdLine,
  output dirState_e        rdState,
  input  logic             engWrEn,
  input  logic [IDX_W-1:0] engWrLine,
  input  dirState_e        engWrState,
  input  logic             grantEn,
  input  logic [IDX_W-1:0] grantLine,
  input  logic [1:0]       grantState
);

  dirState_e lineSt [NUM_LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!rstN) begin
        lineSt[i] <= DIR_E;
      end else if (engWrEn && engWrLine == IDX_W'(i)) begin
        lineSt[i] <= engWrState;
      end else if (grantEn && grantLine == IDX_W'(i) && grantState != 2'd3) begin
        lineSt[i] <= dirState_e'(grantState);
      end
    end
  end

  assign rdState = lineSt[rdLine];

endmodule

// File: rtl/dma_dir_ctrl.sv
module dma_dir_ctrl
  import dma_dir_pkg::*;
#(
  parameter int NUM_CACHES = 3,
  parameter int CNT_W = $clog2(NUM_CACHES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaReqValid,
  input  logic       dmaReqWrite,
  input  dirState_e  reqLineState,
  input  logic       cacheRspValid,
  input  logic [1:0] cacheRspKind,
  input  logic       memRdValid,
  input  logic       memWrAck,
  output logic       dmaReqReady,
  output logic       busy,
  output dpCtl_t     ctl,
  output logic       tblWrEn,
  output dirState_e  tblWrState
);

  typedef enum logic [1:0] {C_IDLE, C_READ, C_WRACK, C_WRMEM} cState_e;

  cState_e state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic memPend, nMemPend;
  logic dirty, nDirty;
  logic sharer, nSharer;
  logic ownerRd, nOwnerRd;
  logic noRd, nNoRd;

  logic rspTake, rspData, rspShared;

  assign rspTake   = cacheRspValid && (state == C_READ || state == C_WRACK) && cnt != '0;
  assign rspData   = cacheRspKind[1];
  assign rspShared = (cacheRspKind == RSP_SHACK) || (cacheRspKind == RSP_SHDATA);

  always_comb begin
    ctl        = '0;
    nState     = state;
    nCnt       = cnt;
    nMemPend   = memPend;
    nDirty     = dirty;
    nSharer    = sharer;
    nOwnerRd   = ownerRd;
    nNoRd      = noRd;
    tblWrEn    = 1'b0;
    tblWrState = DIR_E;

    case (state)
      C_IDLE: begin
        if (dmaReqValid) begin
          ctl.capture    = 1'b1;
          ctl.issueMemRd = !dmaReqWrite && reqLineState != DIR_NO;
          nCnt           = CNT_W'(NUM_CACHES);
          nMemPend       = !dmaReqWrite && reqLineState != DIR_NO;
          nDirty         = 1'b0;
          nSharer        = 1'b0;
          nOwnerRd       = !dmaReqWrite && reqLineState == DIR_O;
          nNoRd          = !dmaReqWrite && reqLineState == DIR_NO;
          nState         = dmaReqWrite ? C_WRACK : C_READ;
        end
      end
      C_READ: begin
        if (cnt == '0 && !memPend) begin
          ctl.sendBuf = !ownerRd;
          ctl.flagErr = noRd && !sharer && !dirty;
          tblWrEn     = 1'b1;
          tblWrState  = (ownerRd || sharer) ? DIR_O : DIR_E;
          nState      = C_IDLE;
        end else if (memPend && memRdValid) begin
          nMemPend    = 1'b0;
          ctl.takeMem = !dirty && !(rspTake && rspData);
          ctl.fwdMem  = ownerRd;
        end
      end
      C_WRACK: begin
        if (cnt == '0) begin
          ctl.issueMemWr = 1'b1;
          ctl.fullLine   = dirty;
          nState         = C_WRMEM;
        end
      end
      C_WRMEM: begin
        if (memWrAck) begin
          ctl.sendAck = 1'b1;
          tblWrEn     = 1'b1;
          tblWrState  = DIR_E;
          nState      = C_IDLE;
        end
      end
      default: nState = C_IDLE;
    endcase

    // every cache response counts once, whatever ack count it carries
    if (rspTake) begin
      nCnt = cnt - CNT_W'(1);
      if (rspData) begin
        ctl.takeCache = 1'b1;
        nDirty        = 1'b1;
      end
      if (rspShared) nSharer = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= C_IDLE;
      cnt     <= '0;
      memPend <= 1'b0;
      dirty   <= 1'b0;
      sharer  <= 1'b0;
      ownerRd <= 1'b0;
      noRd    <= 1'b0;
    end else begin
      state   <= nState;
      cnt     <= nCnt;
      memPend <= nMemPend;
      dirty   <= nDirty;
      sharer  <= nSharer;
      ownerRd <= nOwnerRd;
      noRd    <= nNoRd;
    end
  end

  assign dmaReqReady = (state == C_IDLE);
  assign busy        = (state != C_IDLE);

endmodule

// File: rtl/dma_dir_dpath.sv
module dma_dir_dpath
  import dma_dir_pkg::*;
#(
  parameter int LINE_BYTES = 8,
  parameter int IDX_W = 2,
  parameter int OFS_W = $clog2(LINE_BYTES),
  parameter int LEN_W = OFS_W + 1,
  parameter int DATA_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic                  dmaReqWrite,
  input  logic [IDX_W-1:0]      dmaReqLine,
  input  logic [OFS_W-1:0]      dmaReqOffset,
  input  logic [LEN_W-1:0]      dmaReqLen,
  input  logic [DATA_W-1:0]     dmaReqData,
  input  logic [DATA_W-1:0]     cacheRspData,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [IDX_W-1:0]      activeLine,
  output logic                  probeValid,
  output logic                  probeExcl,
  output logic [IDX_W-1:0]      probeLine,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [IDX_W-1:0]      memReqLine,
  output logic [DATA_W-1:0]     memWrData,
  output logic [LINE_BYTES-1:0] memWrMask,
  output logic                  dmaRspValid,
  output logic                  dmaRspIsData,
  output logic [DATA_W-1:0]     dmaRspData,
  output logic                  protoErr
);

  localparam int SUM_W = LEN_W + 1;

  logic [IDX_W-1:0]      tLine;
  logic [OFS_W-1:0]      tOfs;
  logic [LEN_W-1:0]      tLen;
  logic [DATA_W-1:0]     tData;
  logic [DATA_W-1:0]     lineBuf;
  logic [LINE_BYTES-1:0] dmaMask;
  logic [DATA_W-1:0]     mergedLine;
  logic [SUM_W-1:0]      winStart;
  logic [SUM_W-1:0]      winEnd;

  assign winStart = SUM_W'(tOfs);
  assign winEnd   = SUM_W'(tOfs) + SUM_W'(tLen);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign dmaMask[b] = (SUM_W'(b) >= winStart) && (SUM_W'(b) < winEnd);
    assign mergedLine[8*b +: 8] = dmaMask[b] ? tData[8*b +: 8] : lineBuf[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tLine        <= '0;
      tOfs         <= '0;
      tLen         <= '0;
      tData        <= '0;
      lineBuf      <= '0;
      probeValid   <= 1'b0;
      probeExcl    <= 1'b0;
      probeLine    <= '0;
      memReqValid  <= 1'b0;
      memReqWrite  <= 1'b0;
      memReqLine   <= '0;
      memWrData    <= '0;
      memWrMask    <= '0;
      dmaRspValid  <= 1'b0;
      dmaRspIsData <= 1'b0;
      dmaRspData   <= '0;
      protoErr     <= 1'b0;
    end else begin
      probeValid  <= 1'b0;
      memReqValid <= 1'b0;
      dmaRspValid <= 1'b0;
      protoErr    <= 1'b0;

      if (ctl.capture) begin
        tLine      <= dmaReqLine;
        tOfs       <= dmaReqOffset;
        tLen       <= dmaReqLen;
        tData      <= dmaReqData;
        lineBuf    <= '0;
        probeValid <= 1'b1;
        probeExcl  <= dmaReqWrite;
        probeLine  <= dmaReqLine;
      end
      if (ctl.issueMemRd) begin
        memReqValid <= 1'b1;
        memReqWrite <= 1'b0;
        memReqLine  <= dmaReqLine;
      end
      if (ctl.takeCache) begin
        lineBuf <= cacheRspData;
      end else if (ctl.takeMem) begin
        lineBuf <= memRdData;
      end
      if (ctl.fwdMem) begin
        dmaRspValid  <= 1'b1;
        dmaRspIsData <= 1'b1;
        dmaRspData   <= memRdData;
      end
      if (ctl.sendBuf) begin
        dmaRspValid  <= 1'b1;
        dmaRspIsData <= 1'b1;
        dmaRspData   <= lineBuf;
      end
      if (ctl.flagErr) protoErr <= 1'b1;
      if (ctl.issueMemWr) begin
        memReqValid <= 1'b1;
        memReqWrite <= 1'b1;
        memReqLine  <= tLine;
        memWrData   <= mergedLine;
        memWrMask   <= ctl.fullLine ? '1 : dmaMask;
      end
      if (ctl.sendAck) begin
        dmaRspValid  <= 1'b1;
        dmaRspIsData <= 1'b0;
      end
    end
  end

  assign activeLine = tLine;

endmodule

// File: rtl/dma_dir_engine.sv
module dma_dir_engine
  import dma_dir_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int LINE_BYTES = 8,
  parameter int NUM_CACHES = 3,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LEN_W  = OFS_W + 1,
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dmaReqValid,
  output logic                  dmaReqReady,
  input  logic                  dmaReqWrite,
  input  logic [IDX_W-1:0]      dmaReqLine,
  input  logic [OFS_W-1:0]      dmaReqOffset,
  input  logic [LEN_W-1:0]      dmaReqLen,
  input  logic [DATA_W-1:0]     dmaReqData,
  output logic                  dmaRspValid,
  output logic                  dmaRspIsData,
  output logic [DATA_W-1:0]     dmaRspData,
  output logic                  probeValid,
  output logic                  probeExcl,
  output logic [IDX_W-1:0]      probeLine,
  input  logic                  cacheRspValid,
  input  logic [1:0]            cacheRspKind,
  input  logic [DATA_W-1:0]     cacheRspData,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [IDX_W-1:0]      memReqLine,
  output logic [DATA_W-1:0]     memWrData,
  output logic [LINE_BYTES-1:0] memWrMask,
  input  logic                  memRdValid,
  input  logic [DATA_W-1:0]     memRdData,
  input  logic                  memWrAck,
  input  logic [IDX_W-1:0]      cpuReqLine,
  output logic                  cpuStall,
  input  logic                  cpuGrantValid,
  input  logic [1:0]            cpuGrantState,
  output logic                  protoErr
);

  dpCtl_t           ctl;
  dirState_e        reqLineState;
  dirState_e        tblWrState;
  logic             tblWrEn;
  logic             busy;
  logic [IDX_W-1:0] activeLine;

  assign cpuStall = (busy && cpuReqLine == activeLine) ||
                    (!busy && dmaReqValid && cpuReqLine == dmaReqLine);

  dma_dir_table #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .rdLine     (dmaReqLine),
    .rdState    (reqLineState),
    .engWrEn    (tblWrEn),
    .engWrLine  (activeLine),
    .engWrState (tblWrState),
    .grantEn    (cpuGrantValid && !cpuStall),
    .grantLine  (cpuReqLine),
    .grantState (cpuGrantState)
  );

  dma_dir_ctrl #(.NUM_CACHES(NUM_CACHES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .dmaReqValid   (dmaReqValid),
    .dmaReqWrite   (dmaReqWrite),
    .reqLineState  (reqLineState),
    .cacheRspValid (cacheRspValid),
    .cacheRspKind  (cacheRspKind),
    .memRdValid    (memRdValid),
    .memWrAck      (memWrAck),
    .dmaReqReady   (dmaReqReady),
    .busy          (busy),
    .ctl           (ctl),
    .tblWrEn       (tblWrEn),
    .tblWrState    (tblWrState)
  );

  dma_dir_dpath #(.LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .dmaReqWrite  (dmaReqWrite),
    .dmaReqLine   (dmaReqLine),
    .dmaReqOffset (dmaReqOffset),
    .dmaReqLen    (dmaReqLen),
    .dmaReqData   (dmaReqData),
    .cacheRspData (cacheRspData),
    .memRdData    (memRdData),
    .activeLine   (activeLine),
    .probeValid   (probeValid),
    .probeExcl    (probeExcl),
    .probeLine    (probeLine),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .memReqLine   (memReqLine),
    .memWrData    (memWrData),
    .memWrMask    (memWrMask),
    .dmaRspValid  (dmaRspValid),
    .dmaRspIsData (dmaRspIsData),
    .dmaRspData   (dmaRspData),
    .protoErr     (protoErr)
  );

endmodule

// File: rtl/dma_dir_chk.sv
module dma_dir_chk #(
  parameter int LINE_BYTES = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  dmaReqValid,
  input logic                  dmaReqReady,
  input logic                  dmaReqWrite,
  input logic                  dmaRspValid,
  input logic                  dmaRspIsData,
  input logic                  probeValid,
  input logic                  probeExcl,
  input logic                  memReqValid,
  input logic                  memReqWrite,
  input logic [LINE_BYTES-1:0] memWrMask,
  input logic                  memWrAck,
  input logic                  cpuStall,
  input logic                  protoErr
);

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReqValid && dmaReqReady) |=> !dmaReqReady); // R2

  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !dmaReqValid) |-> !dmaReqReady); // R2

  AST_PROBE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReqValid && dmaReqReady) |=> (probeValid && probeExcl == $past(dmaReqWrite))); // R3

  AST_PROBE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |-> $past(dmaReqValid && dmaReqReady)); // R3

  AST_MEMRD_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> $past(dmaReqValid && dmaReqReady && !dmaReqWrite)); // R4

  AST_WRITE_HAS_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memWrMask != '0); // R9

  AST_ACK_AFTER_MEMWR: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRspValid && !dmaRspIsData) |-> $past(memWrAck)); // R10

  AST_ERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> (dmaRspValid && dmaRspIsData)); // R11

endmodule

bind dma_dir_engine dma_dir_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/sim_dma_dir_engine.sv
module sim_dma_dir_engine;

  localparam int NUM_LINES  = 4;
  localparam int LINE_BYTES = 8;
  localparam int NUM_CACHES = 3;
  localparam int IDX_W      = 2;
  localparam int OFS_W      = 3;
  localparam int LEN_W      = 4;
  localparam int DATA_W     = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaReqValid = 1'b0;
  logic dmaReqReady;
  logic dmaReqWrite = 1'b0;
  logic [IDX_W-1:0] dmaReqLine = '0;
  logic [OFS_W-1:0] dmaReqOffset = '0;
  logic [LEN_W-1:0] dmaReqLen = '0;
  logic [DATA_W-1:0] dmaReqData = '0;
  logic dmaRspValid, dmaRspIsData;
  logic [DATA_W-1:0] dmaRspData;
  logic probeValid, probeExcl;
  logic [IDX_W-1:0] probeLine;
  logic cacheRspValid = 1'b0;
  logic [1:0] cacheRspKind = '0;
  logic [DATA_W-1:0] cacheRspData = '0;
  logic memReqValid, memReqWrite;
  logic [IDX_W-1:0] memReqLine;
  logic [DATA_W-1:0] memWrData;
  logic [LINE_BYTES-1:0] memWrMask;
  logic memRdValid = 1'b0;
  logic [DATA_W-1:0] memRdData = '0;
  logic memWrAck = 1'b0;
  logic [IDX_W-1:0] cpuReqLine = '0;
  logic cpuStall;
  logic cpuGrantValid = 1'b0;
  logic [1:0] cpuGrantState = '0;
  logic protoErr;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dma_dir_engine #(.NUM_LINES(NUM_LINES), .LINE_BYTES(LINE_BYTES), .NUM_CACHES(NUM_CACHES)) u0 (
    .clk(clk), .rstN(rstN),
    .dmaReqValid(dmaReqValid), .dmaReqReady(dmaReqReady), .dmaReqWrite(dmaReqWrite),
    .dmaReqLine(dmaReqLine), .dmaReqOffset(dmaReqOffset), .dmaReqLen(dmaReqLen),
    .dmaReqData(dmaReqData), .dmaRspValid(dmaRspValid), .dmaRspIsData(dmaRspIsData),
    .dmaRspData(dmaRspData), .probeValid(probeValid), .probeExcl(probeExcl),
    .probeLine(probeLine), .cacheRspValid(cacheRspValid), .cacheRspKind(cacheRspKind),
    .cacheRspData(cacheRspData), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqLine(memReqLine), .memWrData(memWrData), .memWrMask(memWrMask),
    .memRdValid(memRdValid), .memRdData(memRdData), .memWrAck(memWrAck),
    .cpuReqLine(cpuReqLine), .cpuStall(cpuStall), .cpuGrantValid(cpuGrantValid),
    .cpuGrantState(cpuGrantState), .protoErr(protoErr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      nFail = nFail + 1;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nFail = nFail + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int ofs, input int len);
    logic [7:0] m = '0;
    for (int i = 0; i < LINE_BYTES; i++) if (i >= ofs && i < ofs + len) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] overlay(input logic [63:0] base, input logic [63:0] d,
                                          input logic [7:0] m);
    logic [63:0] r = base;
    for (int i = 0; i < LINE_BYTES; i++) if (m[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic issue(input bit wr, input int line, input int ofs, input int len,
                       input logic [63:0] d);
    dmaReqValid = 1'b1; dmaReqWrite = wr; dmaReqLine = IDX_W'(line);
    dmaReqOffset = OFS_W'(ofs); dmaReqLen = LEN_W'(len); dmaReqData = d;
    #1;
    chk("R2 ready while idle", dmaReqReady, 1);
    tick();
    dmaReqValid = 1'b0;
    chk("R3 probe pulse", probeValid, 1);
    chk("R3 probe kind", probeExcl, wr);
    chk("R3 probe line", probeLine, line);
    chk("R2 ready low when busy", dmaReqReady, 0);
  endtask

  task automatic rspStep(input logic [1:0] k, input logic [63:0] d);
    cacheRspValid = 1'b1; cacheRspKind = k; cacheRspData = d;
    tick();
    cacheRspValid = 1'b0;
  endtask

  task automatic memStep(input logic [63:0] d, input bit expFwd);
    memRdValid = 1'b1; memRdData = d;
    tick();
    memRdValid = 1'b0;
    chk("R8 forward on memory data", dmaRspValid, expFwd);
    if (expFwd) chk("R8 forwarded line", dmaRspData, d);
  endtask

  // prev: 0=E 1=O 2=NO
  task automatic doRead(input string tag, input int line, input int prev, input bit memFirst,
                        input logic [1:0] k0, input logic [1:0] k1, input logic [1:0] k2,
                        input int gap, input logic [63:0] cD, input logic [63:0] mD,
                        input logic [63:0] expD, input bit expErr);
    logic [1:0] ks [3];
    ks[0] = k0; ks[1] = k1; ks[2] = k2;
    $display("-- %s", tag);
    issue(1'b0, line, 0, 1, 64'h0);
    chk("R4 memory read issued", memReqValid, prev != 2);
    if (prev != 2) begin
      chk("R4 memory read kind", memReqWrite, 0);
      chk("R4 memory read line", memReqLine, line);
    end
    if (prev != 2 && memFirst) memStep(mD, prev == 1);
    for (int i = 0; i < 3; i++) begin
      if (i == 2) begin
        for (int g = 0; g < gap; g++) begin
          tick();
          chk("R5 no completion before last response", dmaRspValid, 0);
        end
      end
      rspStep(ks[i], cD);
      chk("R5 no response yet", dmaRspValid, 0);
    end
    if (prev != 2 && !memFirst) memStep(mD, prev == 1);
    tick();
    if (prev == 1) begin
      chk("R8 no resend at completion", dmaRspValid, 0);
    end else begin
      chk("R7 read response", dmaRspValid, 1);
      chk("R7 response is data", dmaRspIsData, 1);
      chk("R7 response line", dmaRspData, expD);
      chk("R11 protocol error flag", protoErr, expErr);
    end
    tick();
    chk("R2 ready after completion", dmaReqReady, 1);
  endtask

  task automatic doWrite(input string tag, input int line, input int ofs, input int len,
                         input logic [63:0] d, input logic [1:0] k0, input logic [1:0] k1,
                         input logic [1:0] k2, input logic [63:0] cD,
                         input logic [7:0] expMask, input logic [63:0] expD);
    $display("-- %s", tag);
    issue(1'b1, line, ofs, len, d);
    chk("R4 no memory read on write", memReqValid, 0);
    rspStep(k0, cD);
    rspStep(k1, cD);
    rspStep(k2, cD);
    chk("R9 no write before completion", memReqValid, 0);
    tick();
    chk("R9 memory write issued", memReqValid, 1);
    chk("R9 memory write kind", memReqWrite, 1);
    chk("R9 memory write line", memReqLine, line);
    chk("R9 byte mask", memWrMask, expMask);
    chk("R9 merged line", memWrData, expD);
    chk("R10 no ack before memory", dmaRspValid, 0);
    memWrAck = 1'b1;
    tick();
    memWrAck = 1'b0;
    chk("R10 ack response", dmaRspValid, 1);
    chk("R10 ack carries no data", dmaRspIsData, 0);
    tick();
    chk("R2 ready after write", dmaReqReady, 1);
  endtask

  task automatic grant(input int line, input logic [1:0] st);
    cpuReqLine = IDX_W'(line); cpuGrantValid = 1'b1; cpuGrantState = st;
    #1;
    chk("R12 grant not stalled", cpuStall, 0);
    tick();
    cpuGrantValid = 1'b0;
  endtask

  task automatic stallScenario();
    $display("-- stall and ignored grant on open line");
    issue(1'b0, 3, 0, 1, 64'h0);
    dmaReqValid = 1'b1; dmaReqWrite = 1'b1; dmaReqLine = 2'd2;
    cpuReqLine = 2'd3; cpuGrantValid = 1'b1; cpuGrantState = 2'd2;
    #1;
    chk("R2 cpu stall on open line", cpuStall, 1);
    chk("R2 second request not taken", dmaReqReady, 0);
    tick();
    cpuGrantValid = 1'b0; cpuReqLine = 2'd2;
    #1;
    chk("R2 no stall on other line", cpuStall, 0);
    chk("R2 still holding request", dmaReqReady, 0);
    tick();
    dmaReqValid = 1'b0;
    chk("R2 held request caused no probe", probeValid, 0);
    memStep(64'h3333_3333_3333_3333, 1'b0);
    rspStep(2'd0, 64'h0);
    rspStep(2'd0, 64'h0);
    rspStep(2'd0, 64'h0);
    tick();
    chk("R7 stalled-scenario data", dmaRspData, 64'h3333_3333_3333_3333);
    tick();
    // grant during stall was ignored: line 3 still fetches memory (E)
    doRead("R12 line3 still E", 3, 0, 1'b1, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h3434_3434_3434_3434, 64'h3434_3434_3434_3434, 1'b0);
  endtask

  initial begin
    logic [63:0] wd;
    logic [63:0] cd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ready", dmaReqReady, 1);
    chk("R1 rsp", dmaRspValid, 0);
    chk("R1 probe", probeValid, 0);
    chk("R1 memreq", memReqValid, 0);
    chk("R1 err", protoErr, 0);
    chk("R1 stall", cpuStall, 0);

    doRead("R1 line0 E read, memory data", 0, 0, 1'b1, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h1111_0000_1111_0000, 64'h1111_0000_1111_0000, 1'b0);
    doRead("R6 cache data beats later memory, sharer to O", 0, 0, 1'b0, 2'd0, 2'd2, 2'd0, 0,
           64'hCAFE_0001_CAFE_0001, 64'h1111_0000_1111_0000, 64'hCAFE_0001_CAFE_0001, 1'b0);
    doRead("R8 owner read, memory first", 0, 1, 1'b1, 2'd1, 2'd0, 2'd0, 0, 64'h0,
           64'h2222_0000_2222_0000, 64'h0, 1'b0);
    doRead("R8 owner read, memory last, stays O", 0, 1, 1'b0, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h2222_1111_2222_1111, 64'h0, 1'b0);

    wd = 64'h8877_6655_4433_2211;
    doWrite("R9 partial write, clean", 0, 2, 3, wd, 2'd0, 2'd0, 2'd0, 64'h0,
            maskOf(2, 3), overlay(64'h0, wd, maskOf(2, 3)));
    doRead("R10 line0 back to E", 0, 0, 1'b1, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h0000_0055_4433_0000, 64'h0000_0055_4433_0000, 1'b0);

    grant(1, 2'd2);
    doRead("R12 NO read, exclusive data", 1, 2, 1'b0, 2'd0, 2'd3, 2'd0, 0,
           64'hBEEF_BEEF_0000_1234, 64'h0, 64'hBEEF_BEEF_0000_1234, 1'b0);
    doRead("R7 NO read with no sharers left E", 1, 0, 1'b1, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h5555_AAAA_5555_AAAA, 64'h5555_AAAA_5555_AAAA, 1'b0);
    grant(1, 2'd2);
    doRead("R11 NO read, only plain acks", 1, 2, 1'b0, 2'd0, 2'd0, 2'd0, 0, 64'h0,
           64'h0, 64'h0, 1'b1);

    grant(2, 2'd2);
    wd = 64'hF7F6_F5F4_F3F2_F1F0;
    cd = 64'hA7A6_A5A4_A3A2_A1A0;
    doWrite("R9 clipped write over dirty cache line", 2, 6, 4, wd, 2'd3, 2'd0, 2'd0, cd,
            8'hFF, overlay(cd, wd, maskOf(6, 4)));
    doRead("R5 exclusive data counts once", 2, 0, 1'b1, 2'd3, 2'd3, 2'd0, 3,
           64'h7777_0000_7777_0000, 64'h6666_0000_6666_0000, 64'h7777_0000_7777_0000, 1'b0);

    stallScenario();

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule